// File: doc/BRIEF.md
# Serial Transmitter with Holding Queue

The block turns bytes written by a host into asynchronous serial frames on a single output line. The host presents a byte and a one-cycle write strobe. The byte is kept in a holding queue. A mode input selects between a 16-entry first-in first-out queue and a single holding register. Whenever the frame shifter is idle and the queue holds a byte, the shifter takes the oldest byte and builds a frame. The frame is one low start bit, then five to eight data bits with the least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. Every serial bit lasts sixteen pulses of an external 16x oversampling enable. The baud-rate divider that produces that enable is outside the block.

Two status outputs tell the host how far transmission has progressed. `hold_empty` is high while nothing is waiting in the queue. `shift_empty` is high only when the queue is empty and the last stop bit has finished. A maskable interrupt mirrors the holding-empty condition. The line settings are latched when a frame is loaded, so the host may reprogram them for the next byte while the current byte is still being sent.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and `irq` is 0. `txd` stays 1 whenever no frame is in progress.
- R2: Each serial bit is held on `txd` for exactly 16 cycles in which `tick16` is 1. `txd` changes only on the 16th such cycle of a bit, or when a frame is loaded.
- R3: A frame starts with a 0 start bit, followed by the data bits of `wr_data`, bit 0 first. The number of data bits is `wlen`+5: `wlen`=0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper data bits are not sent.
- R4: When `par_en` is 1, one parity bit follows the data bits. With `par_even`=1 the data bits and the parity bit together hold an even number of ones. With `par_even`=0 they hold an odd number. When `par_en` is 0, no parity bit is sent.
- R5: Stop bits are 1 and follow the parity bit, or the data bits when parity is off. `two_stop`=0 sends one stop bit and `two_stop`=1 sends two.
- R6: With `fifo_en`=1, up to 16 accepted bytes queue up and go out in write order. A write while 16 bytes are queued is discarded.
- R7: With `fifo_en`=0, the queue holds at most one byte. A write while that byte is still held is discarded.
- R8: `hold_empty` is 1 exactly when no byte is queued. It falls on the clock edge that accepts a write into an empty queue. It rises on the edge that moves the last queued byte into the shifter.
- R9: `shift_empty` is 1 exactly when `hold_empty` is 1 and the shifter is idle. The shifter becomes idle on the edge that ends the last stop bit.
- R10: `irq` is registered. After each clock edge it equals `irq_en` sampled at that edge ANDed with the new holding-empty state.
- R11: A clock edge at which `fifo_en` differs from its value at the previous edge discards every queued byte and any write in that cycle. A frame already being shifted finishes unchanged.
- R12: An idle shifter loads the oldest queued byte on the edge after it is queued, and `txd` shows the start bit from then on. `wlen`, `par_en`, `par_even` and `two_stop` are captured at load, and later changes do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable, one cycle per pulse |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding register |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| wlen | input | 2 | Data bits minus five |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | 1 adds a parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| txd | output | 1 | Serial data line, high when idle |
| hold_empty | output | 1 | No byte waiting in the holding queue |
| shift_empty | output | 1 | Queue empty and shifter idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench writes back-to-back bursts longer than the queue. A design that let the count wrap or that checked capacity after the pop would send an extra byte or corrupt the order. In single-register mode it writes on the edge right after a load. A design that freed the slot one cycle early would accept a byte that must be dropped. It flips the mode while bytes are queued and a frame is in flight. A missing flush would send stale bytes, and flushing the shifter as well would cut a frame short. It also reprograms the line settings in the middle of a frame and runs the oversampling enable at several duty ratios. Settings that are not latched, or bit timing that counts clocks instead of enables, would show as a `txd` mismatch in the cycle where the line first diverges.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int BYTE_W   = 8;
  localparam int WLEN_MIN = 5;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
  } sertx_cfg_t;

endpackage

// File: rtl/sertx_queue.sv
module sertx_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          empty_nxt
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count_nxt;
  logic          full, push_ok, pop_ok;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  assign empty_nxt = (count_nxt == '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      empty <= 1'b1;
    end else begin
      count <= count_nxt;
      empty <= empty_nxt;
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVS     = 16,
  localparam int DW     = BYTE_W,
  localparam int FRAME_W = 1 + DW + 1 + 2,
  localparam int LW     = $clog2(FRAME_W + 1),
  localparam int TW     = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  sertx_cfg_t    cfg,
  output logic          busy,
  output logic          txd
);

  logic [FRAME_W-1:0] frame, sh;
  logic [LW-1:0]      flen, left;
  logic [TW-1:0]      tcnt;
  logic [3:0]         nbits;
  logic               par;

  always_comb begin
    nbits = 4'(WLEN_MIN) + {2'b00, cfg.wlen};
    frame = '1;
    frame[0] = 1'b0;
    par = ~cfg.par_even;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nbits)) begin
        frame[1 + i] = data[i];
        par = par ^ data[i];
      end
    end
    if (cfg.par_en) frame[1 + nbits] = par;
    flen = LW'(2) + LW'(nbits) + LW'(cfg.par_en) + LW'(cfg.two_stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame;
      left <= flen;
      tcnt <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == TW'(OVS - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
        if (left == LW'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd = sh[0];

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              fifo_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              irq_en,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);

  logic              mode_q, mode_chg, load, busy;
  logic              q_empty, q_empty_nxt, irq_q;
  logic [CW-1:0]     q_count;
  logic [BYTE_W-1:0] q_head;
  sertx_cfg_t        cfg;

  assign mode_chg = fifo_en ^ mode_q;
  assign load     = ~busy & ~q_empty & ~mode_chg;

  assign cfg.wlen     = wlen;
  assign cfg.two_stop = two_stop;
  assign cfg.par_en   = par_en;
  assign cfg.par_even = par_even;

  sertx_queue #(.DW(BYTE_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .flush     (mode_chg),
    .single    (~mode_q),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (load),
    .head      (q_head),
    .count     (q_count),
    .empty     (q_empty),
    .empty_nxt (q_empty_nxt)
  );

  sertx_shifter #(.OVS(OVS)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .tick (tick16),
    .load (load),
    .data (q_head),
    .cfg  (cfg),
    .busy (busy),
    .txd  (txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      irq_q  <= irq_en & q_empty_nxt;
    end
  end

  assign hold_empty  = q_empty;
  assign shift_empty = q_empty & ~busy;
  assign irq         = irq_q;

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick16,
  input logic          txd,
  input logic          hold_empty,
  input logic          shift_empty,
  input logic          irq,
  input logic          busy,
  input logic          mode_q,
  input logic [CW-1:0] q_count
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> txd);

  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick16) |=> $stable(txd));

  assert_stop_last_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(txd));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  assert_single_slot_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (q_count <= CW'(1)));

  assert_shift_implies_hold_R9: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> hold_empty);

  assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> hold_empty);

  assert_start_low_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);

endmodule

bind sertx_core sertx_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick16      (tick16),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .irq         (irq),
  .busy        (busy),
  .mode_q      (mode_q),
  .q_count     (q_count)
);

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       fifo_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] wlen = 2'd3;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       irq_en = 1'b0;
  logic       txd, hold_empty, shift_empty, irq;

  always #2.5 clk = ~clk;

  sertx_core u_sertx_core (
    .clk(clk), .rst(rst), .tick16(tick16), .fifo_en(fifo_en),
    .wr_en(wr_en), .wr_data(wr_data), .wlen(wlen), .two_stop(two_stop),
    .par_en(par_en), .par_even(par_even), .irq_en(irq_en),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  int    tick_div = 1;
  int    tick_cnt = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [7:0]  q[$];
  bit          m_busy = 0, m_mode = 0, m_irq = 0;
  int          m_left = 0, m_tc = 0, m_cnt = 0, m_cap = 0;
  bit          m_chg = 0;
  logic [11:0] m_sh = '1;

  function automatic void start_frame(input logic [7:0] d);
    int nb, pos, ones;
    nb = 5 + int'(wlen);
    m_sh = '1;
    m_sh[0] = 1'b0;
    ones = 0;
    pos = 1;
    for (int k = 0; k < nb; k++) begin
      m_sh[pos] = d[k];
      if (d[k]) ones = ones + 1;
      pos = pos + 1;
    end
    if (par_en) begin
      m_sh[pos] = par_even ? ((ones % 2) == 1) : ((ones % 2) == 0);
      pos = pos + 1;
    end
    m_left = pos + (two_stop ? 2 : 1);
    m_tc = 0;
    m_busy = 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_busy = 0; m_left = 0; m_tc = 0; m_sh = '1; m_mode = 0; m_irq = 0;
    end else begin
      m_cnt = q.size();
      m_chg = (fifo_en != m_mode);
      m_cap = m_mode ? 16 : 1;
      if (!m_busy && m_cnt > 0 && !m_chg) begin
        start_frame(q.pop_front());
      end else if (m_busy && tick16) begin
        if (m_tc == 15) begin
          m_tc = 0;
          m_sh = {1'b1, m_sh[11:1]};
          m_left = m_left - 1;
          if (m_left == 0) m_busy = 0;
        end else begin
          m_tc = m_tc + 1;
        end
      end
      if (m_chg) q.delete();
      else if (wr_en && m_cnt < m_cap) q.push_back(wr_data);
      m_mode = fifo_en;
      m_irq = irq_en && (q.size() == 0);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "txd", txd, m_sh[0]);
      chk("R8", "hold_empty", hold_empty, q.size() == 0);
      chk("R9", "shift_empty", shift_empty, (q.size() == 0) && !m_busy);
      chk("R10", "irq", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst) tick_cnt = 0;
    tick16 = ((tick_cnt % tick_div) == 0);
    tick_cnt = tick_cnt + 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr1(input logic [7:0] b);
    @(posedge clk); #1;
    wr_en = 1'b1;
    wr_data = b;
  endtask

  task automatic wr_stop();
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do begin
      @(posedge clk); #1;
    end while (!(shift_empty && q.size() == 0 && !m_busy));
    step(3);
  endtask

  task automatic set_cfg(input logic [1:0] w, input bit ts, input bit pe, input bit ev);
    wlen = w; two_stop = ts; par_en = pe; par_even = ev;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R1: reset state and idle line
    cur_req = "R1";
    step(6);

    // R7: single register, back-to-back writes
    cur_req = "R7";
    set_cfg(2'd3, 0, 0, 0);
    wr1(8'hA5); wr1(8'h3C); wr1(8'hFF); wr_stop();
    wait_idle();

    // R3: each word length, slower enable
    cur_req = "R3";
    tick_div = 3;
    for (int w = 0; w < 4; w++) begin
      set_cfg(2'(w), 0, 0, 0);
      wr1(8'h5A ^ 8'(w * 17)); wr_stop();
      wait_idle();
    end

    // R4: parity odd and even
    cur_req = "R4";
    for (int p = 0; p < 4; p++) begin
      set_cfg((p < 2) ? 2'd2 : 2'd3, 0, 1, p[0]);
      wr1(p[1] ? 8'h0F : 8'h07); wr_stop();
      wait_idle();
    end

    // R5: two stop bits
    cur_req = "R5";
    set_cfg(2'd0, 1, 1, 1);
    wr1(8'h13); wr_stop();
    wait_idle();
    set_cfg(2'd3, 1, 0, 0);
    wr1(8'h80); wr_stop();
    wait_idle();

    // R6: queue mode, overflow burst
    cur_req = "R6";
    tick_div = 1;
    set_cfg(2'd3, 0, 0, 0);
    @(posedge clk); #1 fifo_en = 1'b1;
    step(2);
    irq_en = 1'b1;
    for (int i = 0; i < 20; i++) wr1(8'(i * 37 + 1));
    wr_stop();
    wait_idle();

    // R10: interrupt enable toggling
    cur_req = "R10";
    irq_en = 1'b0; step(4);
    irq_en = 1'b1; step(4);
    wr1(8'hC3); wr_stop();
    step(30);
    irq_en = 1'b0;
    wait_idle();

    // R11: mode change flushes queue, frame in flight continues
    cur_req = "R11";
    irq_en = 1'b1;
    for (int i = 0; i < 6; i++) wr1(8'(8'hE0 + i));
    wr_stop();
    step(20);
    fifo_en = 1'b0;
    wr_en = 1'b1; wr_data = 8'h99;
    wr_stop();
    wait_idle();

    // R12: settings latched at load
    cur_req = "R12";
    set_cfg(2'd3, 0, 0, 0);
    wr1(8'h6D); wr_stop();
    step(40);
    set_cfg(2'd0, 1, 1, 0);
    wait_idle();
    wr1(8'h6D); wr_stop();
    wait_idle();

    // R2: bit timing under sparse enables
    cur_req = "R2";
    tick_div = 5;
    set_cfg(2'd1, 0, 1, 1);
    wr1(8'h2B); wr_stop();
    wait_idle();
    tick_div = 2;
    @(posedge clk); #1 fifo_en = 1'b1;
    step(2);
    wr1(8'h01); wr1(8'hFE); wr_stop();
    wait_idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule